// File: doc/BRIEF.md
# Break-Before-Make Gate Sequencer

This block turns one PWM command into two drive enables for the high-side and low-side switches of a half bridge. The two enables are never high together. The block does not switch on a simple timer. Each switch turns on only after a comparator flag shows that the gate of the opposite switch has actually discharged below a safe level. Turning on the high side costs a further fixed dead time, counted from the moment the low-side gate is seen discharged. The dead-time length is the elaboration parameter `DEAD_CYCLES` and has no run-time input.

Two override inputs sit above the PWM command. A force-off input removes both enables in the same cycle and holds the sequencer idle. A force-low-side input asks for the low side whatever the PWM command is. If a gate flag never reports discharged, the opposite switch stays off for as long as that lasts. A change of command while a high-side turn-on is pending cancels the pending turn-on, and the sequence starts again.

Top module: `bbm_gate_seq`

## Requirements
- R1: `hsDrive` and `lsDrive` are never 1 in the same cycle.
- R2: With the low side requested (`forceOff`=0 and either `pwmCmd`=0 or `forceLs`=1) and the high side off, `lsDrive` becomes 1 at the first clock edge that samples `hsGateLow`=1, and not earlier.
- R3: With the high side requested (`forceOff`=0, `forceLs`=0, `pwmCmd`=1) and the low side off, take the first edge that samples `lsGateLow`=1. `hsDrive` becomes 1 exactly `DEAD_CYCLES` edges after that edge, provided `lsGateLow` is sampled 1 at every edge in between and at the final edge. If `lsGateLow` is sampled 0 inside that window, the count is dropped and starts again at the next edge that samples it 1.
- R4: While a gate flag stays 0, the opposite drive stays 0 however long the request lasts.
- R5: A change of request while the dead time is counting cancels the pending high-side turn-on. A later high-side request needs a full new dead time.
- R6: `forceOff`=1 forces both drives to 0 in the same cycle, without waiting for a clock edge. After release, each switch turns on only through the R2/R3 sequence.
- R7: `forceLs`=1 selects the low side even while `pwmCmd`=1.
- R8: After reset both drives are 0.
- R9: When the request moves away from a switch that is on, its drive falls at the next clock edge. The other switch then waits for the R2/R3 conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmCmd | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| hsGateLow | input | 1 | Comparator flag: high-side gate below safe level |
| lsGateLow | input | 1 | Comparator flag: low-side gate below safe level |
| forceOff | input | 1 | Turns both drives off at once and holds the sequencer idle |
| forceLs | input | 1 | Requests the low side regardless of `pwmCmd` |
| hsDrive | output | 1 | High-side drive enable |
| lsDrive | output | 1 | Low-side drive enable |

## Verification
The assertions assume that every input, `forceOff` included, changes only between clock edges and is steady at each rising edge. Without that, the same-cycle path from `forceOff` could show a rise of a drive that no edge caused. The bench drives all inputs at the falling edge and uses `#1` only to observe the combinational effect of `forceOff`. The gate flags are treated as free-running inputs with no tie to the drives. The stimulus therefore includes flags that stay stuck, flags that reassert part-way through a dead-time count, and random flag patterns. The R3 assertion only needs the sampled `lsGateLow` history to cover the dead-time window.

// File: rtl/bbm_pkg.sv
`timescale 1ns/1ps
package bbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HS   = 2'd1,
    ST_LS   = 2'd2,
    ST_DEAD = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_HS   = 2'd1,
    REQ_LS   = 2'd2
  } driveReq_t;

  typedef struct packed {
    logic cntClr;
    logic cntStep;
  } ctlStrobes_t;

endpackage

// File: rtl/bbm_drive_path.sv
`timescale 1ns/1ps
module bbm_drive_path
  import bbm_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        hsOn,
  input  logic        lsOn,
  input  logic        forceOff,
  output logic        deadDone,
  output logic        hsDrive,
  output logic        lsDrive
);

  localparam int CNT_W = $clog2(DEAD_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

  logic [CNT_W-1:0] deadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deadCnt <= '0;
    else if (strobes.cntClr)  deadCnt <= '0;
    else if (strobes.cntStep) deadCnt <= deadCnt + 1'b1;
  end

  assign deadDone = (deadCnt == LAST);

  // forceOff acts without waiting for a clock edge
  assign hsDrive = hsOn & ~forceOff;
  assign lsDrive = lsOn & ~forceOff;

endmodule

// File: rtl/bbm_seq_ctrl.sv
`timescale 1ns/1ps
module bbm_seq_ctrl
  import bbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmCmd,
  input  logic        forceOff,
  input  logic        forceLs,
  input  logic        hsGateLow,
  input  logic        lsGateLow,
  input  logic        deadDone,
  output ctlStrobes_t strobes,
  output logic        hsOn,
  output logic        lsOn
);

  seqState_t st, nxt;
  driveReq_t req;

  always_comb begin
    if (forceOff)               req = REQ_NONE;
    else if (forceLs || !pwmCmd) req = REQ_LS;
    else                        req = REQ_HS;
  end

  always_comb begin
    nxt = st;
    unique case (req)
      REQ_NONE: nxt = ST_IDLE;
      REQ_LS: begin
        if (st == ST_HS)      nxt = ST_IDLE;
        else if (st != ST_LS) nxt = hsGateLow ? ST_LS : ST_IDLE;
      end
      REQ_HS: begin
        if (st == ST_LS)        nxt = ST_IDLE;
        else if (st == ST_DEAD) begin
          if (!lsGateLow)       nxt = ST_IDLE;
          else if (deadDone)    nxt = ST_HS;
        end
        else if (st == ST_IDLE) nxt = lsGateLow ? ST_DEAD : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    strobes.cntClr  = (st != ST_DEAD);
    strobes.cntStep = (st == ST_DEAD) && (nxt == ST_DEAD);
  end

  assign hsOn = (st == ST_HS);
  assign lsOn = (st == ST_LS);

endmodule

// File: rtl/bbm_gate_seq.sv
`timescale 1ns/1ps
module bbm_gate_seq
  import bbm_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmCmd,
  input  logic hsGateLow,
  input  logic lsGateLow,
  input  logic forceOff,
  input  logic forceLs,
  output logic hsDrive,
  output logic lsDrive
);

  ctlStrobes_t strobes;
  logic hsOn, lsOn, deadDone;

  bbm_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .forceOff(forceOff),
    .forceLs(forceLs), .hsGateLow(hsGateLow), .lsGateLow(lsGateLow),
    .deadDone(deadDone), .strobes(strobes), .hsOn(hsOn), .lsOn(lsOn)
  );

  bbm_drive_path #(.DEAD_CYCLES(DEAD_CYCLES)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hsOn(hsOn), .lsOn(lsOn),
    .forceOff(forceOff), .deadDone(deadDone),
    .hsDrive(hsDrive), .lsDrive(lsDrive)
  );

endmodule

// File: rtl/bbm_gate_seq_chk.sv
`timescale 1ns/1ps
module bbm_gate_seq_chk #(
  parameter int DEAD_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic pwmCmd,
  input logic hsGateLow,
  input logic lsGateLow,
  input logic forceOff,
  input logic forceLs,
  input logic hsDrive,
  input logic lsDrive
);

  // run of consecutive sampled edges with the low-side gate discharged and off
  int lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= 0;
    else if (lsGateLow && !lsDrive) begin
      if (lowRun <= DEAD_CYCLES) lowRun <= lowRun + 1;
    end
    else lowRun <= 0;
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsDrive && lsDrive));

  // R2
  ls_after_hs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsDrive) |-> $past(hsGateLow));

  // R3
  hs_after_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsDrive) |-> (lowRun >= DEAD_CYCLES));

  // R6
  force_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |=> (!hsDrive && !lsDrive));

  // R7
  force_ls_no_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsDrive) |-> $past(pwmCmd && !forceLs));

  // R9
  ls_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsDrive) |-> $past(!pwmCmd || forceLs));

endmodule

bind bbm_gate_seq bbm_gate_seq_chk #(.DEAD_CYCLES(DEAD_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .hsGateLow(hsGateLow),
  .lsGateLow(lsGateLow), .forceOff(forceOff), .forceLs(forceLs),
  .hsDrive(hsDrive), .lsDrive(lsDrive)
);

// File: tb/bbm_gate_seq_tb_top.sv
`timescale 1ns/1ps
module bbm_gate_seq_tb_top;

  localparam int DT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmCmd = 1'b0, hsGateLow = 1'b0, lsGateLow = 1'b0;
  logic forceOff = 1'b0, forceLs = 1'b0;
  logic hsDrive, lsDrive;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit mHs = 0, mLs = 0;
  int mDead = -1;

  always #4 clk = ~clk;

  bbm_gate_seq #(.DEAD_CYCLES(DT)) dut_i (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .hsGateLow(hsGateLow),
    .lsGateLow(lsGateLow), .forceOff(forceOff), .forceLs(forceLs),
    .hsDrive(hsDrive), .lsDrive(lsDrive)
  );

  task automatic modelStep();
    int want;
    if (!rstN) begin mHs = 0; mLs = 0; mDead = -1; return; end
    if (forceOff)               want = 0;
    else if (forceLs || !pwmCmd) want = 2;
    else                        want = 1;
    if (want == 0) begin
      mHs = 0; mLs = 0; mDead = -1;
    end else if (want == 2) begin
      mDead = -1;
      if (mHs) mHs = 0;
      else if (!mLs && hsGateLow) mLs = 1;
    end else begin
      if (mLs) begin mLs = 0; mDead = -1; end
      else if (!mHs) begin
        if (mDead >= 0) begin
          if (!lsGateLow) mDead = -1;
          else if (mDead == DT - 1) begin mHs = 1; mDead = -1; end
          else mDead++;
        end else if (lsGateLow) mDead = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    bit eH, eL;
    eH = mHs && !forceOff;
    eL = mLs && !forceOff;
    checks++;
    if (hsDrive !== eH || lsDrive !== eL) begin
      failures++;
      $display("FAIL %s hs=%0b ls=%0b expected hs=%0b ls=%0b at %0t",
               tag, hsDrive, lsDrive, eH, eL, $time);
    end
    checks++;
    if (hsDrive === 1'b1 && lsDrive === 1'b1) begin
      failures++;
      $display("FAIL R1 hs=%0b ls=%0b expected not both 1", hsDrive, lsDrive);
    end
  endtask

  task automatic cyc(input int n, input string tag);
    repeat (n) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic drive(input bit p, input bit hg, input bit lg,
                       input bit fo, input bit fl, input string tag);
    pwmCmd = p; hsGateLow = hg; lsGateLow = lg; forceOff = fo; forceLs = fl;
    #1 compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    cyc(3, "R8");
    @(negedge clk) rstN = 1'b1;
    compare("R8");

    // R3: high side after dead time
    drive(1, 0, 1, 0, 0, "R3");
    cyc(DT + 3, "R3");

    // R9: high side drops at next edge; R4: stuck high-side flag blocks low side
    drive(0, 0, 1, 0, 0, "R9");
    cyc(1, "R9");
    cyc(6, "R4");
    // R2: low side when flag reports discharged
    drive(0, 1, 1, 0, 0, "R2");
    cyc(3, "R2");

    // R3: dead count restarts when low-side flag drops mid-window
    drive(1, 1, 0, 0, 0, "R9");
    cyc(3, "R4");
    drive(1, 1, 1, 0, 0, "R3");
    cyc(2, "R3");
    drive(1, 1, 0, 0, 0, "R3");
    cyc(1, "R3");
    drive(1, 1, 1, 0, 0, "R3");
    cyc(DT + 2, "R3");

    // R5: command change during pending dead time cancels turn-on
    drive(0, 1, 1, 0, 0, "R5");
    cyc(2, "R5");
    drive(1, 1, 0, 0, 0, "R5");
    cyc(2, "R5");
    drive(1, 1, 1, 0, 0, "R5");
    cyc(2, "R5");
    drive(0, 0, 1, 0, 0, "R5");
    cyc(1, "R5");
    drive(1, 0, 1, 0, 0, "R5");
    cyc(DT + 2, "R5");

    // R6: force-off removes drive in the same cycle and restarts sequence
    drive(1, 0, 1, 1, 0, "R6");
    cyc(3, "R6");
    drive(1, 0, 1, 0, 0, "R6");
    cyc(DT + 2, "R6");
    drive(0, 1, 1, 0, 0, "R6");
    cyc(3, "R6");
    drive(0, 1, 1, 1, 0, "R6");
    cyc(2, "R6");
    drive(0, 1, 1, 0, 0, "R6");
    cyc(2, "R6");

    // R7: force low side overrides a high command
    drive(1, 1, 1, 0, 1, "R7");
    cyc(DT + 3, "R7");
    drive(1, 1, 1, 0, 0, "R7");
    cyc(DT + 3, "R7");
    drive(1, 1, 1, 0, 1, "R7");
    cyc(3, "R7");

    // mixed random stimulus, R1 on every cycle
    for (int i = 0; i < 600; i++) begin
      bit p, hg, lg, fo, fl;
      p  = ($urandom % 6 == 0) ? ~pwmCmd : pwmCmd;
      hg = ($urandom % 4 != 0) ? ~hsDrive : hsGateLow;
      lg = ($urandom % 4 != 0) ? ~lsDrive : lsGateLow;
      fo = ($urandom % 20 == 0);
      fl = ($urandom % 10 == 0);
      drive(p, hg, lg, fo, fl, "R1");
      cyc(1 + ($urandom % 3), "R1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule